// File: doc/BRIEF.md
# Eight-Channel Down-Counter Timer Bank

The block holds eight independent 32-bit timers that count down by one on every clock while enabled. Software reaches them through a plain memory-mapped port with an address, write data, byte enables, a write strobe and a read strobe. Each timer owns two words: a control word that holds an enable bit and a two-bit mode, and a count word that loads the live counter and the stored period at the same time.

Three behaviours are selectable per timer. A free-running timer wraps from zero to all-ones without ever signalling. A one-shot timer signals once when it expires and then turns itself off. A periodic timer signals on each expiry and restarts from the stored period. Each timer has its own interrupt line, driven as a one-cycle pulse per expiry, so a tick source, a timeout source and a free-running time base can share the bank without interfering.

Top module: `timer_bank`

## Requirements
- R1: After reset every timer is disabled in free-running mode with count and period zero, every interrupt bit is low and the read data is zero.
- R2: Timer t owns the control word at byte address 8*t and the count word at 8*t+4; addresses whose two low bits are not zero are ignored by writes and read back as zero.
- R3: A control write takes effect only when byte enable 0 is set; write data bit 0 sets the enable and bits 5:4 the mode; a control read returns the enable in bit 0, the mode in bits 5:4 and zeros elsewhere.
- R4: A count write takes effect only when all four byte enables are set and loads both the live counter and the stored period; a partial write changes nothing.
- R5: An enabled timer whose count is not zero decrements by one per clock; a disabled timer keeps its count.
- R6: In mode 0 (and in the unassigned mode 3) an enabled timer at zero wraps to all-ones on the next clock and never pulses its interrupt.
- R7: In mode 1 an enabled timer at zero pulses its interrupt for exactly one cycle on the next clock, clears its own enable bit and holds its count at zero.
- R8: In mode 2 an enabled timer at zero pulses its interrupt for one cycle on the next clock and reloads the stored period, so a period value of N gives a pulse every N+1 clocks.
- R9: A read strobe samples the addressed word as it stands in that cycle; the value appears on the read data from the next cycle and holds until the next read strobe.
- R10: A count write in the same cycle as a decrement or an expiry wins over it, and a control write in the same cycle as a one-shot expiry wins over the self-clear; the expiry still pulses the interrupt.
- R11: Interrupt bit t reflects timer t alone; several timers running at once pulse their own bits independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for a write |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| tmr_irq | output | 8 | One-cycle expiry pulse per timer |

## Verification
The assertions assume the write and read strobes are known every cycle after reset and that an access presents a stable address, data and byte-enable set for the single cycle its strobe is high. The decoder check further assumes at most one word is written per cycle, which holds because the port carries one address. The stimulus changes inputs only on the falling edge, holds each access for exactly one cycle, and includes back-to-back writes aimed at the exact expiry cycle so the priority rules are reached inside those assumptions.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'd0,
        MODE_ONCE     = 2'd1,
        MODE_RELOAD   = 2'd2,
        MODE_FREE_ALT = 2'd3
    } tmr_mode_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_MODE_LO = 4;
    localparam int CTRL_MODE_HI = 5;

endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec #(
    parameter int NUM_TMR = 8,
    parameter int BE_W    = 4,
    localparam int IDX_W  = $clog2(NUM_TMR),
    localparam int ADDR_W = IDX_W + 3
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BE_W-1:0]    be,
    input  logic               wr,
    output logic [NUM_TMR-1:0] ctrl_we,
    output logic [NUM_TMR-1:0] cnt_we,
    output logic [IDX_W-1:0]   sel_idx,
    output logic               sel_cnt,
    output logic               sel_ok
);

    logic aligned;
    logic ctrl_hit;
    logic cnt_hit;

    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        sel_idx  = addr[ADDR_W-1:3];
        sel_cnt  = addr[2];
        sel_ok   = aligned;
        ctrl_hit = wr && aligned && !addr[2] && be[0];
        cnt_hit  = wr && aligned && addr[2] && (&be);
    end

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_dec
        assign ctrl_we[t] = ctrl_hit && (sel_idx == IDX_W'(t));
        assign cnt_we[t]  = cnt_hit  && (sel_idx == IDX_W'(t));
    end

    // R2
    always_comb begin
        one_word_chk: assert ($onehot0({ctrl_we, cnt_we}));
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import timer_bank_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] ctrl_rd,
    output logic [CNT_W-1:0] cnt_rd,
    output logic             irq
);

    typedef struct packed {
        logic             en;
        tmr_mode_e        mode;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic             irq;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (st_q.en) begin
            if (st_q.cnt == '0) begin
                unique case (st_q.mode)
                    MODE_ONCE: begin
                        st_d.irq = 1'b1;
                        st_d.en  = 1'b0;
                    end
                    MODE_RELOAD: begin
                        st_d.irq = 1'b1;
                        st_d.cnt = st_q.per;
                    end
                    default: st_d.cnt = st_q.cnt - 1'b1;
                endcase
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (ctrl_we) begin
            st_d.en   = wdata[CTRL_EN_BIT];
            st_d.mode = tmr_mode_e'(wdata[CTRL_MODE_HI:CTRL_MODE_LO]);
        end
        if (cnt_we) begin
            st_d.cnt = wdata;
            st_d.per = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ctrl_rd                            = '0;
        ctrl_rd[CTRL_EN_BIT]               = st_q.en;
        ctrl_rd[CTRL_MODE_HI:CTRL_MODE_LO] = st_q.mode;
    end

    assign cnt_rd = st_q.cnt;
    assign irq    = st_q.irq;

    // R5
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && st_q.cnt != '0 && !cnt_we) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && !cnt_we) |=> $stable(st_q.cnt));

    // R6
    free_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && (st_q.mode == MODE_FREE || st_q.mode == MODE_FREE_ALT)) |=> !irq);

    // R7
    once_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && st_q.mode == MODE_ONCE && st_q.cnt == '0 && !ctrl_we) |=> (!st_q.en && irq));

    // R8
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && st_q.mode == MODE_RELOAD && st_q.cnt == '0 && !cnt_we)
        |=> (irq && st_q.cnt == $past(st_q.per)));

    // R7
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(st_q.en));

endmodule

// File: rtl/timer_bank.sv
module timer_bank
    import timer_bank_pkg::*;
#(
    parameter int NUM_TMR = 8,
    parameter int CNT_W   = 32,
    localparam int BE_W   = CNT_W / 8,
    localparam int IDX_W  = $clog2(NUM_TMR),
    localparam int ADDR_W = IDX_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CNT_W-1:0]   bus_wdata,
    input  logic [BE_W-1:0]    bus_be,
    input  logic               bus_wr,
    input  logic               bus_rd,
    output logic [CNT_W-1:0]   bus_rdata,
    output logic [NUM_TMR-1:0] tmr_irq
);

    logic [NUM_TMR-1:0] ctrl_we;
    logic [NUM_TMR-1:0] cnt_we;
    logic [IDX_W-1:0]   sel_idx;
    logic               sel_cnt;
    logic               sel_ok;
    logic [CNT_W-1:0]   ctrl_v [NUM_TMR];
    logic [CNT_W-1:0]   cnt_v  [NUM_TMR];
    logic [CNT_W-1:0]   rdata_d, rdata_q;

    tmr_regdec #(
        .NUM_TMR (NUM_TMR),
        .BE_W    (BE_W)
    ) i_dec (
        .addr    (bus_addr),
        .be      (bus_be),
        .wr      (bus_wr),
        .ctrl_we (ctrl_we),
        .cnt_we  (cnt_we),
        .sel_idx (sel_idx),
        .sel_cnt (sel_cnt),
        .sel_ok  (sel_ok)
    );

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        tmr_channel #(
            .CNT_W (CNT_W)
        ) i_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (ctrl_we[t]),
            .cnt_we  (cnt_we[t]),
            .wdata   (bus_wdata),
            .ctrl_rd (ctrl_v[t]),
            .cnt_rd  (cnt_v[t]),
            .irq     (tmr_irq[t])
        );
    end

    always_comb begin
        rdata_d = rdata_q;
        if (bus_rd) begin
            if (!sel_ok)      rdata_d = '0;
            else if (sel_cnt) rdata_d = cnt_v[sel_idx];
            else              rdata_d = ctrl_v[sel_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/test_timer_bank.sv
`timescale 1ns/1ps
module test_timer_bank;

    localparam int NT = 8;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr  = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  be    = '0;
    logic        wr    = 1'b0;
    logic        rd    = 1'b0;
    logic [31:0] rdata;
    logic [7:0]  irq;

    int    nchk  = 0;
    int    nfail = 0;
    bit    done  = 0;
    bit    live  = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    timer_bank i_timer_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_be    (be),
        .bus_wr    (wr),
        .bus_rd    (rd),
        .bus_rdata (rdata),
        .tmr_irq   (irq)
    );

    // behavioural reference model
    bit        m_en   [NT];
    bit [1:0]  m_mode [NT];
    bit [31:0] m_cnt  [NT];
    bit [31:0] m_per  [NT];
    bit [7:0]  m_irq;
    bit [31:0] m_rdata;

    always @(posedge clk) begin
        int  ti;
        bit  ok;
        bit  fire;
        ti = int'(addr[5:3]);
        ok = (addr[1:0] == 2'b00);
        if (!rst_n) begin
            for (int k = 0; k < NT; k++) begin
                m_en[k] = 0; m_mode[k] = 0; m_cnt[k] = 0; m_per[k] = 0;
            end
            m_irq   = 0;
            m_rdata = 0;
        end else begin
            if (rd) begin
                if (!ok)         m_rdata = 0;
                else if (addr[2]) m_rdata = m_cnt[ti];
                else             m_rdata = {26'd0, m_mode[ti], 3'd0, m_en[ti]};
            end
            for (int k = 0; k < NT; k++) begin
                fire = 0;
                if (m_en[k]) begin
                    if (m_cnt[k] != 0)       m_cnt[k] = m_cnt[k] - 1;
                    else if (m_mode[k] == 1) begin fire = 1; m_en[k] = 0; end
                    else if (m_mode[k] == 2) begin fire = 1; m_cnt[k] = m_per[k]; end
                    else                     m_cnt[k] = 32'hFFFF_FFFF;
                end
                if (wr && ok && ti == k) begin
                    if (!addr[2] && be[0]) begin
                        m_en[k]   = wdata[0];
                        m_mode[k] = wdata[5:4];
                    end
                    if (addr[2] && be == 4'hF) begin
                        m_cnt[k] = wdata;
                        m_per[k] = wdata;
                    end
                end
                m_irq[k] = fire;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // compare outputs on every falling edge
    always @(negedge clk) begin
        if (live && rst_n) begin
            chk(cur_req, "irq", {24'd0, irq}, {24'd0, m_irq});
            chk(cur_req, "rdata", rdata, m_rdata);
        end
    end

    task automatic quiet();
        wr = 0; rd = 0; be = 0; wdata = 0; addr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); quiet(); end
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk); quiet();
        addr = a; wdata = d; be = b; wr = 1;
    endtask

    task automatic rd_reg(input logic [5:0] a);
        @(negedge clk); quiet();
        addr = a; rd = 1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        live  = 1;

        // R1: reset state of every word
        cur_req = "R1";
        chk("R1", "irq after reset", {24'd0, irq}, 32'd0);
        chk("R1", "rdata after reset", rdata, 32'd0);
        for (int t = 0; t < NT; t++) begin
            rd_reg(6'(8 * t));
            rd_reg(6'(8 * t + 4));
        end
        idle(2);

        // R2 / R3: control layout, byte enable, misaligned access
        cur_req = "R3";
        wr_reg(6'd24, 32'h0000_0020, 4'h1);
        rd_reg(6'd24);
        wr_reg(6'd24, 32'h0000_0011, 4'h2);
        rd_reg(6'd24);
        cur_req = "R2";
        wr_reg(6'd25, 32'h0000_0031, 4'hF);
        rd_reg(6'd25);
        rd_reg(6'd24);
        idle(2);

        // R4: full and partial count writes
        cur_req = "R4";
        wr_reg(6'd20, 32'd100, 4'hF);
        rd_reg(6'd20);
        wr_reg(6'd20, 32'h0000_0005, 4'h3);
        rd_reg(6'd20);
        idle(1);

        // R5: decrement while enabled, hold while disabled
        cur_req = "R5";
        wr_reg(6'd16, 32'h0000_0001, 4'h1);
        idle(5);
        rd_reg(6'd20);
        wr_reg(6'd16, 32'h0, 4'h1);
        idle(4);
        rd_reg(6'd20);
        idle(1);

        // R6: free-running wrap, modes 0 and 3
        cur_req = "R6";
        wr_reg(6'd4, 32'd3, 4'hF);
        wr_reg(6'd0, 32'h0000_0001, 4'h1);
        idle(4);
        rd_reg(6'd4);
        idle(3);
        wr_reg(6'd52, 32'd1, 4'hF);
        wr_reg(6'd48, 32'h0000_0031, 4'h1);
        idle(3);
        rd_reg(6'd52);
        idle(2);

        // R7: one-shot expiry and self-clear
        cur_req = "R7";
        wr_reg(6'd12, 32'd4, 4'hF);
        wr_reg(6'd8, 32'h0000_0011, 4'h1);
        idle(8);
        rd_reg(6'd8);
        rd_reg(6'd12);
        idle(2);

        // R8: periodic reload, period value 2
        cur_req = "R8";
        wr_reg(6'd44, 32'd2, 4'hF);
        wr_reg(6'd40, 32'h0000_0021, 4'h1);
        idle(12);
        rd_reg(6'd40);
        idle(1);

        // R9: read data holds between strobes
        cur_req = "R9";
        rd_reg(6'd44);
        idle(6);
        rd_reg(6'd4);
        idle(3);

        // R10: writes colliding with expiry
        cur_req = "R10";
        wr_reg(6'd36, 32'd0, 4'hF);
        wr_reg(6'd32, 32'h0000_0011, 4'h1);
        wr_reg(6'd32, 32'h0000_0011, 4'h1);
        idle(3);
        rd_reg(6'd32);
        wr_reg(6'd44, 32'd7, 4'hF);
        idle(2);
        wr_reg(6'd44, 32'd1, 4'hF);
        idle(6);

        // R11: many timers at once
        cur_req = "R11";
        for (int t = 0; t < NT; t++) begin
            wr_reg(6'(8 * t + 4), 32'(t + 1), 4'hF);
            wr_reg(6'(8 * t), (t % 2 == 0) ? 32'h21 : 32'h11, 4'h1);
        end
        idle(30);
        for (int t = 0; t < NT; t++) wr_reg(6'(8 * t), 32'h0, 4'h1);
        idle(3);

        done = 1;
        live = 0;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule